// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block is a free-running up-counter with a single compare channel that drives one waveform pin. The counter advances by one on every cycle in which the timer-clock enable is high. It rolls over from its all-ones value to zero, and a sticky overflow flag is raised on the same edge. Whenever the counter equals the compare value on an enabled cycle, a sticky match flag is raised. The compare output state is then updated according to a 2-bit action field.

Software uses a small register port to set the counter, the compare value and a control word, and to read back state. The control word holds the action field, the pin direction, a general-purpose output level and a force strobe. The force strobe applies an action at once, without a match, so the output state can be preset before the pin is enabled. Two acknowledge inputs clear the two sticky flags, standing in for interrupt service.

Top module: `timer_cmp_wave`

## Requirements
- R1: On each cycle with `tick` high and no counter write, the counter increments by one; without `tick` it holds. From 0xFFFF it goes to 0x0000.
- R2: The overflow flag (status bit 0) is set on the edge where counting takes the counter from 0xFFFF to 0. It stays set until `ovf_ack` is high on a cycle with no new overflow. An overflow on the same cycle as `ovf_ack` leaves the flag set.
- R3: A match happens on a `tick` cycle where the counter equals the compare register (address 1). A match sets the match flag (status bit 1) and applies the selected action. The counter keeps counting and is not cleared. `cmp_ack` clears the match flag, and a new match wins over `cmp_ack`.
- R4: The action field is control bits [1:0]: 00 leaves the output state unchanged, 01 toggles it, 10 clears it and 11 sets it. The output state is readable at status bit 2.
- R5: Writing the control register without the force bit never changes the output state. A newly written action is used from the next match on.
- R6: Writing control with bit 4 set (force) applies the action written in the same word at once. A force does not set the match flag and does not change the counter. Bit 4 reads back as 0.
- R7: When a force and a match fall on the same cycle, the action is applied once: a toggle inverts the state exactly once.
- R8: `pin_oe` equals the direction bit (control bit 2). With `pin_oe` high, `pin_out` carries the output state if the action field is nonzero, and the general-purpose level (control bit 3) otherwise. With `pin_oe` low, `pin_out` is 0.
- R9: A counter write (address 0) loads the value at any time and takes priority over a `tick` on the same cycle. No match is detected on the first `tick` after a counter write.
- R10: The output state can be preset by a force while the direction bit is 0. It appears on `pin_out` once the direction bit is set.
- R11: After reset all registers and flags are 0. `rd_data` shows, one clock later, the register selected by `rd_addr`: 0 counter, 1 compare, 2 control, 3 status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| ovf_ack | input | 1 | Clears the overflow flag |
| cmp_ack | input | 1 | Clears the match flag |
| pin_out | output | 1 | Waveform pin level |
| pin_oe | output | 1 | Waveform pin output enable |

## Verification
Two pairs of functions can land on one edge. In the first, a force strobe coincides with a compare match. The bench provokes this by loading the counter one below the compare value, stepping once so the write blockade is gone, and then driving `tick` together with a control write that carries the force bit. With a toggle action, the output state must flip exactly once and the match flag must still be set. In the second, an overflow coincides with its acknowledge, and the flag must remain set. A counter write on a `tick` cycle is also checked, and the written value must win.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  typedef enum logic [1:0] {
    OCM_NONE   = 2'b00,
    OCM_TOGGLE = 2'b01,
    OCM_CLEAR  = 2'b10,
    OCM_SET    = 2'b11
  } ocm_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

  localparam int CB_DIR   = 2;
  localparam int CB_IO    = 3;
  localparam int CB_FORCE = 4;

  function automatic logic ocm_apply(input ocm_e m, input logic cur);
    case (m)
      OCM_TOGGLE: ocm_apply = ~cur;
      OCM_CLEAR:  ocm_apply = 1'b0;
      OCM_SET:    ocm_apply = 1'b1;
      default:    ocm_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/tcw_counter.sv
module tcw_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] cmp_val,
  input  logic         ovf_ack,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         match
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic blocked;
  logic step;
  logic wrap;

  assign step  = tick && !wr_cnt;
  assign wrap  = step && (count == CNT_MAX);
  assign match = step && !blocked && (count == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      blocked <= 1'b0;
    end else if (wr_cnt) begin
      count   <= wr_val;
      blocked <= 1'b1;
    end else if (tick) begin
      count   <= count + CNT_ONE;
      blocked <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_ack) ovf_flag <= 1'b0;
  end

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cnt && count == CNT_MAX) |=> (count == '0));
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt) |=> $stable(count));
  a_r2_ovf_raised: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cnt && count == CNT_MAX) |=> ovf_flag);
  a_r3_no_clear_on_match: assert property (@(posedge clk) disable iff (rst)
    match |=> (count == $past(count) + CNT_ONE));
  a_r9_write_blocks_match: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> !match);
endmodule

// File: rtl/tcw_cmpout.sv
module tcw_cmpout
  import tcw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic force_act,
  input  ocm_e mode,
  input  ocm_e force_mode,
  input  logic cmp_ack,
  output logic oc_state,
  output logic cmp_flag
);
  ocm_e act_mode;
  logic act;

  assign act_mode = force_act ? force_mode : mode;
  assign act      = match || force_act;

  always_ff @(posedge clk) begin
    if (rst)      oc_state <= 1'b0;
    else if (act) oc_state <= ocm_apply(act_mode, oc_state);
  end

  always_ff @(posedge clk) begin
    if (rst)          cmp_flag <= 1'b0;
    else if (match)   cmp_flag <= 1'b1;
    else if (cmp_ack) cmp_flag <= 1'b0;
  end

  a_r3_flag_on_match: assert property (@(posedge clk) disable iff (rst)
    match |=> cmp_flag);
  a_r6_force_no_flag: assert property (@(posedge clk) disable iff (rst)
    (force_act && !match && !cmp_flag) |=> !cmp_flag);
  a_r4_none_holds: assert property (@(posedge clk) disable iff (rst)
    (act && act_mode == OCM_NONE) |=> $stable(oc_state));
  a_r7_single_toggle: assert property (@(posedge clk) disable iff (rst)
    (force_act && match && force_mode == OCM_TOGGLE) |=> (oc_state != $past(oc_state)));
endmodule

// File: rtl/timer_cmp_wave.sv
module timer_cmp_wave
  import tcw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic              ovf_ack,
  input  logic              cmp_ack,
  output logic              pin_out,
  output logic              pin_oe
);
  localparam int CTRL_W = 4;
  localparam int STAT_W = 3;

  logic [W-1:0] cmp_q;
  ocm_e         mode_q;
  logic         dir_q;
  logic         io_q;

  logic         wr_cnt, wr_cmp, wr_ctrl, force_act;
  ocm_e         wr_mode;
  logic [W-1:0] count;
  logic         ovf_flag, match, oc_state, cmp_flag;
  logic [CTRL_W-1:0] ctrl_view;
  logic [STAT_W-1:0] stat_view;

  assign wr_cnt    = wr_en && (wr_addr == A_COUNT);
  assign wr_cmp    = wr_en && (wr_addr == A_CMP);
  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_mode   = ocm_e'(wr_data[1:0]);
  assign force_act = wr_ctrl && wr_data[CB_FORCE];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mode_q <= OCM_NONE;
      dir_q  <= 1'b0;
      io_q   <= 1'b0;
    end else begin
      if (wr_cmp) cmp_q <= wr_data;
      if (wr_ctrl) begin
        mode_q <= wr_mode;
        dir_q  <= wr_data[CB_DIR];
        io_q   <= wr_data[CB_IO];
      end
    end
  end

  tcw_counter #(.W(W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_cnt   (wr_cnt),
    .wr_val   (wr_data),
    .cmp_val  (cmp_q),
    .ovf_ack  (ovf_ack),
    .count    (count),
    .ovf_flag (ovf_flag),
    .match    (match)
  );

  tcw_cmpout u_cmpout (
    .clk        (clk),
    .rst        (rst),
    .match      (match),
    .force_act  (force_act),
    .mode       (mode_q),
    .force_mode (wr_mode),
    .cmp_ack    (cmp_ack),
    .oc_state   (oc_state),
    .cmp_flag   (cmp_flag)
  );

  assign ctrl_view = {io_q, dir_q, mode_q};
  assign stat_view = {oc_state, cmp_flag, ovf_flag};

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_COUNT: rd_data <= count;
        A_CMP:   rd_data <= cmp_q;
        A_CTRL:  rd_data <= {{(W-CTRL_W){1'b0}}, ctrl_view};
        default: rd_data <= {{(W-STAT_W){1'b0}}, stat_view};
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = dir_q && ((mode_q != OCM_NONE) ? oc_state : io_q);

  a_r5_ctrl_write_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !force_act && !match) |=> $stable(oc_state));
  a_r8_pin_quiet_when_input: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wr_data[CB_DIR]) |=> (!pin_oe && !pin_out));
endmodule

// File: tb/test_timer_cmp_wave.sv
module test_timer_cmp_wave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr_en = 1'b0, ovf_ack = 1'b0, cmp_ack = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  timer_cmp_wave #(.W(16)) i_timer_cmp_wave (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_ack(ovf_ack), .cmp_ack(cmp_ack), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic acks();
    @(negedge clk); ovf_ack = 1'b1; cmp_ack = 1'b1;
    @(negedge clk); ovf_ack = 1'b0; cmp_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R11 reset register", v, 16'h0);
    end
    chk("R11 reset pin_oe", {15'h0, pin_oe}, 16'h0);
    chk("R11 reset pin_out", {15'h0, pin_out}, 16'h0);
  endtask

  task automatic t_count();
    logic [15:0] v;
    wr(2'd0, 16'h0005); ticks(3);
    rd(2'd0, v); chk("R1 count after 3 ticks", v, 16'h0008);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 hold without tick", v, 16'h0008);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    wr(2'd1, 16'h0020);
    wr(2'd0, 16'hFFFE); ticks(1);
    rd(2'd0, v); chk("R1 count at max", v, 16'hFFFF);
    rd(2'd3, v); chk("R2 no flag before wrap", v & 16'h1, 16'h0);
    ticks(1);
    rd(2'd0, v); chk("R1 wrap to zero", v, 16'h0000);
    rd(2'd3, v); chk("R2 flag on wrap", v & 16'h1, 16'h1);
    ticks(2);
    rd(2'd3, v); chk("R2 flag sticky", v & 16'h1, 16'h1);
    acks();
    rd(2'd3, v); chk("R2 flag cleared by ack", v & 16'h1, 16'h0);
    wr(2'd0, 16'hFFFF);
    @(negedge clk); tick = 1'b1; ovf_ack = 1'b1;
    @(negedge clk); tick = 1'b0; ovf_ack = 1'b0;
    rd(2'd3, v); chk("R2 overflow wins over ack", v & 16'h1, 16'h1);
    acks();
  endtask

  task automatic run_match(input logic [1:0] mode, input logic oc_before, input logic oc_after, input string req);
    logic [15:0] v;
    wr(2'd2, {12'h0, 2'b01, mode});
    rd(2'd3, v); chk("R5 mode write keeps state", (v >> 2) & 16'h1, {15'h0, oc_before});
    wr(2'd0, 16'h001F); ticks(2);
    rd(2'd3, v); chk(req, v, {13'h0, oc_after, 1'b1, 1'b0});
    acks();
  endtask

  task automatic t_modes();
    logic [15:0] v;
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'h0010); ticks(17);
    rd(2'd0, v); chk("R3 counter not cleared by match", v, 16'h0021);
    rd(2'd3, v); chk("R3 R4 toggle on match sets flag", v, 16'h0006);
    acks();
    rd(2'd3, v); chk("R3 cmp_ack clears flag", v, 16'h0004);
    run_match(2'b10, 1'b1, 1'b0, "R4 clear action");
    run_match(2'b11, 1'b0, 1'b1, "R4 set action");
    run_match(2'b00, 1'b1, 1'b1, "R4 none action");
    run_match(2'b01, 1'b1, 1'b0, "R4 toggle action");
  endtask

  task automatic t_force();
    logic [15:0] v;
    wr(2'd2, 16'h0015);
    rd(2'd3, v); chk("R6 force toggles, no flag", v, 16'h0004);
    rd(2'd0, v); chk("R6 force leaves counter", v, 16'h0021);
    rd(2'd2, v); chk("R6 force bit reads 0", v, 16'h0005);
    wr(2'd2, 16'h0014);
    rd(2'd3, v); chk("R6 force none keeps state", v, 16'h0004);
    wr(2'd2, 16'h0016);
    rd(2'd3, v); chk("R6 force clear", v, 16'h0000);
    wr(2'd2, 16'h0017);
    rd(2'd3, v); chk("R6 force set", v, 16'h0004);
  endtask

  task automatic t_race();
    logic [15:0] v;
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'h001F); ticks(1);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0015;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(2'd3, v); chk("R7 force+match toggles once", v, 16'h0002);
    rd(2'd0, v); chk("R7 counter advanced", v, 16'h0021);
    acks();
  endtask

  task automatic t_cntwr();
    logic [15:0] v;
    wr(2'd0, 16'h0020); ticks(1);
    rd(2'd3, v); chk("R9 match blocked after write", v & 16'h2, 16'h0);
    rd(2'd0, v); chk("R9 counter advanced", v, 16'h0021);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0100;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(2'd0, v); chk("R9 write wins over tick", v, 16'h0100);
  endtask

  task automatic t_pin();
    logic [15:0] v;
    wr(2'd2, 16'h0001);
    rd(2'd3, v); chk("R10 state before preset", v & 16'h4, 16'h0);
    wr(2'd2, 16'h0011);
    chk("R10 preset hidden oe", {15'h0, pin_oe}, 16'h0);
    chk("R10 preset hidden out", {15'h0, pin_out}, 16'h0);
    wr(2'd2, 16'h0005);
    chk("R8 R10 enabled oe", {15'h0, pin_oe}, 16'h1);
    chk("R10 preset visible", {15'h0, pin_out}, 16'h1);
    wr(2'd2, 16'h000C);
    chk("R8 io level high", {15'h0, pin_out}, 16'h1);
    wr(2'd2, 16'h0004);
    chk("R8 io level low", {15'h0, pin_out}, 16'h0);
    wr(2'd2, 16'h0008);
    chk("R8 input oe", {15'h0, pin_oe}, 16'h0);
    chk("R8 input out", {15'h0, pin_out}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_overflow();
    t_modes();
    t_force();
    t_race();
    t_cntwr();
    t_pin();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule